// File: doc/BRIEF.md
# Block-Mode FIFO Service Controller

This block sits between a register bus and an external serial shift engine. Software does not move data word by word under a free-running loop. It works in blocks of up to four words. A per-direction service flag says that a block of output space is free or that a block of received data is ready. Software acknowledges the flag by writing a one to it, then moves the block through the data ports. The output and input FIFOs and the shifter live outside the block. The block sees them through FIFO level inputs, push and pop strobes, and one-cycle engine events (a word taken for transmission, a word received).

A two-bit core state (reset, run, pause) selects what the engine may do. A state change is accepted only while a valid flag is high. Valid drops for one cycle after every accepted change. Transfer counts of up to 65535 words per direction can be loaded only in the reset state. Each direction can be switched off, and each direction reports completion through a done flag. Four sticky error flags record pushes into a full FIFO and pops from an empty one, and a mask register routes them onto a single interrupt line. A write to the software-reset address returns every register to its default.

Top module: `qsvc_ctrl`

## Requirements
- R1: The state field (address 0, bits 1:0) uses 0 = reset, 1 = run, 3 = pause, and bit 2 reads as a valid flag. After reset the register reads 4. A write is accepted only while valid is 1. Valid reads 0 in the cycle after an accepted write and 1 again after that. A write of code 2, or any write while valid is 0, leaves the state unchanged.
- R2: The output count (address 2) and input count (address 3) are 16 bits wide. They can be written only while the state is reset, and a write in any other state leaves the stored value unchanged.
- R3: In run, with output enabled, the output service flag (status bit 8) rises when no block is outstanding, output words remain, and free output FIFO space is at least min(4, remaining). It rises once per block. It does not rise again until software has pushed that block's words.
- R4: In run, with input enabled, the input service flag (status bit 9) rises when no block is outstanding, input words remain, and the input FIFO level is at least min(4, remaining). A final partial block raises it only once its last word has arrived.
- R5: Writing status (address 4) with bit 8 or bit 9 set clears that service flag. A zero in that bit leaves the flag unchanged.
- R6: Status bit 4 shows output FIFO not empty, bit 5 input not empty, bit 6 output full, and bit 7 input full.
- R7: Status bit 10 (output done) is set once the engine has taken the programmed number of output words. Bit 11 (input done) is set once software has popped the programmed number of input words. A zero count in an enabled direction sets its done bit in the cycle after run is entered. The configuration register (address 1) disables output with bit 0 and input with bit 1.
- R8: The error register (address 5) holds input overrun at bit 2, output underrun at bit 3, input underrun at bit 4 and output overrun at bit 5. The flags are sticky and are cleared by writing one. The interrupt output is high whenever a flag is set together with its bit in the enable register (address 6).
- R9: A write to address 8 pushes the word into the output FIFO only when the FIFO is not full. A read of address 9 pops the input FIFO only when it is not empty.
- R10: Returning the state to reset clears the service flags, the done flags and the transfer progress. A write to address 7 restores every register to its reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops on the receive data address) |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| ofifo_push | output | 1 | Push strobe to the output FIFO |
| ofifo_data | output | 32 | Word pushed into the output FIFO |
| ofifo_level | input | 4 | Output FIFO occupancy |
| ififo_pop | output | 1 | Pop strobe to the input FIFO |
| ififo_data | input | 32 | Head word of the input FIFO |
| ififo_level | input | 4 | Input FIFO occupancy |
| eng_take | input | 1 | Engine takes one word from the output FIFO |
| eng_put | input | 1 | Engine delivers one received word to the input FIFO |
| eng_run | output | 1 | Engine may shift (state is run) |
| err_irq | output | 1 | Masked error interrupt |

## Verification
The embedded assertions check, on every cycle, the rules that are local: an illegal state code never appears, valid drops after an accepted write, a write while not valid changes nothing, counts stay frozen outside reset, pushes and pops never hit a full or empty FIFO, and a service flag only rises out of run with a bounded outstanding block. The bench's count sweeps are what show the arithmetic across a whole transfer. They check block sizes including the short final block, one flag per block, done timing for zero and nonzero counts, and correct clearing on a return to reset. The error-flag scenarios check each fault condition and the interrupt masking.

// File: rtl/qsvc_pkg.sv
// Shared types and register addresses for the block-mode FIFO service controller.
package qsvc_pkg;
    typedef enum logic [1:0] {
        ST_RESET = 2'd0,
        ST_RUN   = 2'd1,
        ST_PAUSE = 2'd3
    } core_state_e;

    localparam logic [3:0] A_STATE  = 4'd0;
    localparam logic [3:0] A_CFG    = 4'd1;
    localparam logic [3:0] A_OCNT   = 4'd2;
    localparam logic [3:0] A_ICNT   = 4'd3;
    localparam logic [3:0] A_STATUS = 4'd4;
    localparam logic [3:0] A_ERR    = 4'd5;
    localparam logic [3:0] A_ERREN  = 4'd6;
    localparam logic [3:0] A_SWRST  = 4'd7;
    localparam logic [3:0] A_TX     = 4'd8;
    localparam logic [3:0] A_RX     = 4'd9;
endpackage

// File: rtl/qsvc_state.sv
// Core state holder with valid handshake.
// Assumes: a write is honoured only while valid is high; code 2 is not a state.
module qsvc_state
    import qsvc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        soft_rst,
    input  logic        wr,
    input  logic [1:0]  code,
    output core_state_e state,
    output logic        valid
);
    // Accept a legal code while valid, then hold valid low for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            state <= ST_RESET;
            valid <= 1'b1;
        end else if (wr && valid && code != 2'd2) begin
            state <= core_state_e'(code);
            valid <= 1'b0;
        end else begin
            valid <= 1'b1;
        end
    end

    p_legal_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
        state != 2'd2);
    p_valid_drop_r1: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        (wr && valid && code != 2'd2) |=> !valid);
    p_busy_ignore_r1: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        (wr && !valid) |=> $stable(state));
endmodule

// File: rtl/qsvc_dir.sv
// One transfer direction: progress counters, block grant, service flag and done flag.
// Assumes: avail is free space (output) or fill level (input); sw_ev is one software
// push or pop; eng_ev is one engine word; clr holds everything idle (reset state).
module qsvc_dir #(
    parameter int CNT_W   = 16,
    parameter int LVL_W   = 4,
    parameter int BLK     = 4,
    parameter bit SW_DONE = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             run,
    input  logic [CNT_W-1:0] cnt,
    input  logic             eng_ev,
    input  logic             sw_ev,
    input  logic [LVL_W-1:0] avail,
    input  logic             ack,
    output logic             svc,
    output logic             done
);
    localparam int BW = $clog2(BLK + 1);

    logic [CNT_W-1:0] eng_n, sw_n, rem;
    logic [BW-1:0]    grant, blk;
    logic             set_svc;
    logic [CNT_W-1:0] done_n;

    // Words software still has to move, and the size of the next block.
    always_comb begin
        rem     = cnt - sw_n;
        blk     = (rem >= CNT_W'(BLK)) ? BW'(BLK) : rem[BW-1:0];
        set_svc = en && run && grant == '0 && rem != '0 &&
                  CNT_W'(avail) >= CNT_W'(blk);
    end

    generate
        if (SW_DONE) begin : g_sw_done
            assign done_n = sw_n;
        end else begin : g_eng_done
            assign done_n = eng_n;
        end
    endgenerate

    // Progress counting, block grant bookkeeping, flag set/clear and done.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            eng_n <= '0;
            sw_n  <= '0;
            grant <= '0;
            svc   <= 1'b0;
            done  <= 1'b0;
        end else begin
            if (en && eng_ev && eng_n != cnt) eng_n <= eng_n + 1'b1;
            if (en && sw_ev && sw_n != cnt)   sw_n  <= sw_n + 1'b1;
            if (set_svc)                      grant <= blk - BW'(sw_ev);
            else if (sw_ev && grant != '0)    grant <= grant - 1'b1;
            if (set_svc)                      svc <= 1'b1;
            else if (ack)                     svc <= 1'b0;
            done <= en && done_n == cnt;
        end
    end

    p_svc_from_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(svc) |-> $past(run) && $past(en));
    p_grant_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        grant <= BW'(BLK));
endmodule

// File: rtl/qsvc_ctrl.sv
// Register front end of the block-mode FIFO service controller. Decodes the bus,
// drives FIFO push/pop, keeps configuration, counts and sticky error flags, and
// instantiates the state holder and one direction unit per direction.
// Assumes: external FIFOs of DEPTH words report their level; engine strobes are one cycle.
module qsvc_ctrl
    import qsvc_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int BLK   = 4,
    parameter int CNT_W = 16,
    parameter int DW    = 32,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [3:0]       bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    output logic             ofifo_push,
    output logic [DW-1:0]    ofifo_data,
    input  logic [LVL_W-1:0] ofifo_level,
    output logic             ififo_pop,
    input  logic [DW-1:0]    ififo_data,
    input  logic [LVL_W-1:0] ififo_level,
    input  logic             eng_take,
    input  logic             eng_put,
    output logic             eng_run,
    output logic             err_irq
);
    localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

    core_state_e      state;
    logic             valid, soft_rst, clr;
    logic [1:0]       cfg_off;
    logic [CNT_W-1:0] cnt_q [2];
    logic [5:2]       err, err_en, err_new;
    logic             wr_tx, rd_rx, o_full, i_full, o_empty, i_empty;
    logic [1:0]       d_en, d_eng, d_sw, d_ack, d_svc, d_done;
    logic [LVL_W-1:0] d_avail [2];

    // Bus decode and FIFO strobes.
    always_comb begin
        soft_rst   = bus_wr && bus_addr == A_SWRST;
        clr        = state == ST_RESET;
        wr_tx      = bus_wr && bus_addr == A_TX;
        rd_rx      = bus_rd && bus_addr == A_RX;
        o_full     = ofifo_level == FULL;
        i_full     = ififo_level == FULL;
        o_empty    = ofifo_level == '0;
        i_empty    = ififo_level == '0;
        ofifo_push = wr_tx && !o_full;
        ofifo_data = bus_wdata;
        ififo_pop  = rd_rx && !i_empty;
        eng_run    = state == ST_RUN;
        err_new    = {wr_tx && o_full, rd_rx && i_empty,
                      eng_take && o_empty, eng_put && i_full};
        err_irq    = |(err & err_en);
    end

    qsvc_state u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .wr       (bus_wr && bus_addr == A_STATE),
        .code     (bus_wdata[1:0]),
        .state    (state),
        .valid    (valid)
    );

    // Per-direction hookup: index 0 is output, index 1 is input.
    always_comb begin
        d_en       = ~cfg_off;
        d_eng      = {eng_put && !i_full, eng_take && !o_empty};
        d_sw       = {ififo_pop, ofifo_push};
        d_ack      = {2{bus_wr && bus_addr == A_STATUS}} & bus_wdata[9:8];
        d_avail[0] = FULL - ofifo_level;
        d_avail[1] = ififo_level;
    end

    generate
        for (genvar gi = 0; gi < 2; gi++) begin : g_dir
            qsvc_dir #(
                .CNT_W   (CNT_W),
                .LVL_W   (LVL_W),
                .BLK     (BLK),
                .SW_DONE (gi == 1)
            ) u_dir (
                .clk    (clk),
                .rst_n  (rst_n && !soft_rst),
                .clr    (clr),
                .en     (d_en[gi]),
                .run    (eng_run),
                .cnt    (cnt_q[gi]),
                .eng_ev (d_eng[gi]),
                .sw_ev  (d_sw[gi]),
                .avail  (d_avail[gi]),
                .ack    (d_ack[gi]),
                .svc    (d_svc[gi]),
                .done   (d_done[gi])
            );
        end
    endgenerate

    // Configuration, counts (reset state only) and sticky error flags.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            cfg_off  <= '0;
            cnt_q[0] <= '0;
            cnt_q[1] <= '0;
            err      <= '0;
            err_en   <= '0;
        end else begin
            if (bus_wr && bus_addr == A_CFG)         cfg_off  <= bus_wdata[1:0];
            if (bus_wr && bus_addr == A_OCNT && clr) cnt_q[0] <= bus_wdata[CNT_W-1:0];
            if (bus_wr && bus_addr == A_ICNT && clr) cnt_q[1] <= bus_wdata[CNT_W-1:0];
            if (bus_wr && bus_addr == A_ERREN)       err_en   <= bus_wdata[5:2];
            err <= (err & ~((bus_wr && bus_addr == A_ERR) ? bus_wdata[5:2] : 4'b0))
                   | err_new;
        end
    end

    // Read mux.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_STATE:  bus_rdata[2:0] = {valid, state};
            A_CFG:    bus_rdata[1:0] = cfg_off;
            A_OCNT:   bus_rdata[CNT_W-1:0] = cnt_q[0];
            A_ICNT:   bus_rdata[CNT_W-1:0] = cnt_q[1];
            A_STATUS: bus_rdata[11:4] = {d_done[1], d_done[0], d_svc[1], d_svc[0],
                                         i_full, o_full, !i_empty, !o_empty};
            A_ERR:    bus_rdata[5:2] = err;
            A_ERREN:  bus_rdata[5:2] = err_en;
            A_RX:     bus_rdata = ififo_data;
            default:  bus_rdata = '0;
        endcase
    end

    p_cnt_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_OCNT && state != ST_RESET) |=> $stable(cnt_q[0]));
    p_push_room_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ofifo_push |-> ofifo_level < FULL);
    p_pop_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ififo_pop |-> ififo_level != '0);
endmodule

// File: tb/sim_qsvc_ctrl.sv
module sim_qsvc_ctrl;
    import qsvc_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        ofifo_push, ififo_pop, eng_run, err_irq;
    logic [31:0] ofifo_data;
    logic [31:0] ififo_data = 32'hA5A5_0000;
    logic [3:0]  olvl, ilvl;
    logic        eng_take = 1'b0, eng_put = 1'b0;
    int          checks = 0, errors = 0;
    bit          done_flag = 1'b0;

    always #5 clk = ~clk;

    qsvc_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ofifo_push(ofifo_push), .ofifo_data(ofifo_data), .ofifo_level(olvl),
        .ififo_pop(ififo_pop), .ififo_data(ififo_data), .ififo_level(ilvl),
        .eng_take(eng_take), .eng_put(eng_put), .eng_run(eng_run), .err_irq(err_irq)
    );

    // External FIFO occupancy models, driven only from port activity.
    always @(posedge clk) begin
        if (!rst_n) begin
            olvl <= '0;
            ilvl <= '0;
        end else begin
            olvl <= olvl + 4'(ofifo_push) - 4'(eng_take && olvl != 0);
            ilvl <= ilvl + 4'(eng_put && ilvl != 8) - 4'(ififo_pop);
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bwr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic brd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulse_take();
        @(negedge clk); eng_take = 1'b1;
        @(negedge clk); eng_take = 1'b0;
    endtask

    task automatic pulse_put();
        @(negedge clk); eng_put = 1'b1;
        @(negedge clk); eng_put = 1'b0;
    endtask

    task automatic go_state(input logic [1:0] s);
        bwr(A_STATE, {30'd0, s});
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        int pushed, got, blk;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset value, illegal code, accepted write, busy write ignored
        peek(A_STATE, v);  check("R1 reset state", v, 32'h4);
        peek(A_STATUS, v); check("R6 reset status", v, 32'h0);
        bwr(A_STATE, 32'd2);
        peek(A_STATE, v);  check("R1 code 2 ignored", v, 32'h4);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = A_STATE; bus_wdata = 32'd1;
        @(negedge clk);
        bus_wdata = 32'd3;
        #1 v = bus_rdata;  check("R1 valid low after write", v, 32'h1);
        @(negedge clk);
        bus_wr = 1'b0;
        peek(A_STATE, v);  check("R1 write while busy ignored", v, 32'h5);

        // R2: count lock outside reset, full width in reset
        bwr(A_OCNT, 32'h1234);
        peek(A_OCNT, v);   check("R2 count locked in run", v, 32'h0);
        go_state(2'd0);
        bwr(A_OCNT, 32'hFFFF);
        peek(A_OCNT, v);   check("R2 count 16-bit in reset", v, 32'hFFFF);

        // R3 R5 R7 R9: output sweep with engine draining
        for (int n = 0; n <= 9; n++) begin
            bwr(A_SWRST, 0);
            bwr(A_CFG, 32'h2);
            bwr(A_OCNT, n);
            go_state(2'd1);
            peek(A_STATUS, v); check("R7 output done at start", 32'(v[10]), 32'(n == 0));
            pushed = 0;
            while (pushed < n) begin
                blk = (n - pushed > 4) ? 4 : n - pushed;
                @(negedge clk);
                peek(A_STATUS, v); check("R3 output service raised", 32'(v[8]), 32'h1);
                bwr(A_STATUS, 32'h0);
                peek(A_STATUS, v); check("R5 zero write keeps flag", 32'(v[8]), 32'h1);
                bwr(A_STATUS, 32'h100);
                peek(A_STATUS, v); check("R5 one clears flag", 32'(v[8]), 32'h0);
                for (int k = 0; k < blk; k++) bwr(A_TX, 32'hC0DE_0000 + 32'(pushed + k));
                peek(A_STATUS, v); check("R6 output not empty", 32'(v[4]), 32'h1);
                check("R9 output level", 32'(olvl), 32'(blk));
                check("R7 output not done before drain", 32'(v[10]), 32'h0);
                for (int k = 0; k < blk; k++) pulse_take();
                pushed += blk;
            end
            @(negedge clk);
            peek(A_STATUS, v); check("R7 output done", 32'(v[10]), 32'h1);
            check("R3 no flag when nothing remains", 32'(v[8]), 32'h0);
        end

        // R4 R7 R9: input sweep, flag only after a whole (or final partial) block
        for (int n = 0; n <= 9; n++) begin
            bwr(A_SWRST, 0);
            bwr(A_CFG, 32'h1);
            bwr(A_ICNT, n);
            go_state(2'd1);
            peek(A_STATUS, v); check("R7 input done at start", 32'(v[11]), 32'(n == 0));
            got = 0;
            while (got < n) begin
                blk = (n - got > 4) ? 4 : n - got;
                for (int k = 0; k < blk; k++) begin
                    pulse_put();
                    @(negedge clk);
                    peek(A_STATUS, v);
                    check("R4 input flag at block fill", 32'(v[9]), 32'(k == blk - 1));
                end
                bwr(A_STATUS, 32'h200);
                for (int k = 0; k < blk; k++) brd(A_RX, v);
                got += blk;
                @(negedge clk);
                peek(A_STATUS, v); check("R7 input done after drain", 32'(v[11]), 32'(got == n));
                check("R9 input drained", 32'(ilvl), 32'h0);
            end
        end

        // R10: return to reset clears flags; soft reset restores defaults
        bwr(A_SWRST, 0);
        bwr(A_OCNT, 6);
        go_state(2'd1);
        @(negedge clk);
        peek(A_STATUS, v); check("R3 flag before reset", 32'(v[8]), 32'h1);
        go_state(2'd0);
        peek(A_STATUS, v); check("R10 reset clears flags", v & 32'hF00, 32'h0);
        bwr(A_ERREN, 32'h3C);
        bwr(A_SWRST, 0);
        peek(A_OCNT, v);   check("R10 soft reset count", v, 32'h0);
        peek(A_ERREN, v);  check("R10 soft reset enable", v, 32'h0);
        peek(A_STATE, v);  check("R10 soft reset state", v, 32'h4);

        // R6 R8 R9: error flags and masking
        bwr(A_ERREN, 32'h20);
        for (int k = 0; k < 8; k++) bwr(A_TX, k);
        peek(A_STATUS, v); check("R6 output full", v & 32'hF0, 32'h50);
        bwr(A_TX, 32'h99);
        check("R9 no push when full", 32'(olvl), 32'h8);
        peek(A_ERR, v);    check("R8 output overrun", v, 32'h20);
        check("R8 irq enabled", 32'(err_irq), 32'h1);
        bwr(A_ERR, 32'h20);
        peek(A_ERR, v);    check("R8 write-one clears", v, 32'h0);
        check("R8 irq cleared", 32'(err_irq), 32'h0);
        brd(A_RX, v);
        peek(A_ERR, v);    check("R8 input underrun", v, 32'h10);
        check("R8 irq masked", 32'(err_irq), 32'h0);
        for (int k = 0; k < 9; k++) pulse_take();
        peek(A_ERR, v);    check("R8 output underrun", v, 32'h18);
        for (int k = 0; k < 9; k++) pulse_put();
        peek(A_STATUS, v); check("R6 input full", v & 32'hF0, 32'hA0);
        peek(A_ERR, v);    check("R8 input overrun", v, 32'h1C);

        done_flag = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule